// File: doc/BRIEF.md
# Staged Dual Health-Relay Self-Test Sequencer

This block runs the periodic self-test of an evaluator that has no duplicate. The evaluator holds two health relays energised in series. Each relay on its own can cut the secure bus that feeds all of the evaluator's output relays. If that bus is dead, every output relay falls, and every block the outputs report on reads as occupied. A single supervision input tells the block whether the bus is live. No output relay has its own checkback.

When a test is requested, the sequencer drops health relay one and waits for the supervision input to go off. It then restores the relay and waits for the input to come back on. After that it does the same two steps with health relay two. Each wait has a timeout that software sets. If a wait expires, the block drops both relays and latches an alarm. If all four checks succeed, the block gives a one-cycle pass pulse. Outside a test, both relays follow the evaluator's health input.

Top module: `hrst_top`

## Requirements
- R1: With no test running and no alarm, both relay drives equal `healthy_i` in the same cycle, and `busy_o` is low.
- R2: A start request is accepted only when `start_i` and `healthy_i` are both high in idle with no alarm. It is then sampled on a clock edge, and `busy_o` rises in the next cycle. A request made while unhealthy or alarmed leaves `busy_o` low and both relay drives unchanged.
- R3: The first phase of the test has `relay1_o` low and `relay2_o` high. It waits for `sup_i` to read 0.
- R4: The second phase has both relay drives high. It waits for `sup_i` to read 1.
- R5: The third phase has `relay1_o` high and `relay2_o` low, and waits for `sup_i` = 0. The fourth phase has both drives high and waits for `sup_i` = 1.
- R6: After the fourth check matches, `pass_o` is high for exactly one cycle, and `busy_o` is low in that same cycle. `pass_o` is never high otherwise.
- R7: Each phase counts the cycles it has waited, starting from 0 in its first cycle. A matching `sup_i` always advances the phase, even in the cycle where the count equals `timeout_i`. So a response that arrives `timeout_i` cycles after phase entry passes. One cycle later, it fails.
- R8: A wait that expires sets `alarm_o` in the next cycle. `alarm_o` then stays high until reset. While it is high, both relay drives are low, `busy_o` is low and start requests are ignored.
- R9: If `healthy_i` goes low during a test, the test aborts to idle in the next cycle, with no pass and no alarm. The relay drives follow `healthy_i` while it is low.
- R10: After reset, the block is idle, and `alarm_o` and `pass_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| healthy_i | input | 1 | Evaluator health; 1 = healthy |
| start_i | input | 1 | Self-test request |
| sup_i | input | 1 | Combined supervision input; 1 = secure bus live |
| timeout_i | input | TW (16) | Last wait count allowed per phase |
| relay1_o | output | 1 | Drive for health relay one; 1 = energised |
| relay2_o | output | 1 | Drive for health relay two; 1 = energised |
| busy_o | output | 1 | A test is in progress |
| pass_o | output | 1 | One-cycle pulse when all four checks succeed |
| alarm_o | output | 1 | Latched test failure |

## Verification
The sharpest collision is a supervision match and a timeout expiry in the same cycle. The bench provokes it with a model of the bus that delays `sup_i` by exactly `timeout_i` cycles after the relay changes. The run must then end in a pass, and a delay one cycle longer must end in the alarm. A second collision is `healthy_i` falling during a wait. It is judged against a reference model that compares every output on every clock, and must end with neither pass nor alarm.

// File: rtl/hrst_pkg.sv
// Shared types for the health-relay self-test sequencer.
// Assumes exactly two series health relays, tested in index order.
package hrst_pkg;
    localparam int NUM_HEALTH = 2;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_DROP1  = 3'd1,
        ST_RAISE1 = 3'd2,
        ST_DROP2  = 3'd3,
        ST_RAISE2 = 3'd4
    } hrst_state_e;

    // Level the supervision input must reach in a given phase
    function automatic logic want_live(input hrst_state_e s);
        return (s == ST_RAISE1) || (s == ST_RAISE2);
    endfunction

    // True for the four phases that wait on the supervision input
    function automatic logic is_wait(input hrst_state_e s);
        return s != ST_IDLE;
    endfunction
endpackage

// File: rtl/hrst_wait_timer.sv
// Wait counter for one supervision phase.
// Counts from 0 after a clear and stops at the limit. expired_o is high
// once the count has reached the limit. Assumes the limit is held steady
// through a phase.
module hrst_wait_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic [TW-1:0] limit_i,
    output logic          expired_o
);
    logic [TW-1:0] cnt_q;

    assign expired_o = (cnt_q >= limit_i);

    // Count waited cycles; restart on clear, hold at the limit
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt_q <= '0;
        end else if (!expired_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R7: a clear always restarts the count at zero
    assert_clear_restarts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (cnt_q == '0));

    // R7: the count never moves without a clear once expired
    assert_holds_at_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (expired_o && !clear_i && $stable(limit_i)) |=> $stable(cnt_q));
endmodule

// File: rtl/hrst_sequencer.sv
// Phase sequencer of the self-test.
// It steps through four phases: drop relay one, raise it, drop relay two,
// raise it. It advances on a supervision match and fails on timer expiry.
// It also holds the latched alarm and the pass pulse. Assumes sup_i is
// already synchronous to clk.
module hrst_sequencer
    import hrst_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  healthy_i,
    input  logic                  start_i,
    input  logic                  sup_i,
    input  logic                  expired_i,
    output logic                  timer_clear_o,
    output logic [NUM_HEALTH-1:0] drop_o,
    output logic                  busy_o,
    output logic                  pass_o,
    output logic                  alarm_o
);
    hrst_state_e state_q;
    hrst_state_e state_nxt;
    logic        matched;
    logic        accept;

    assign matched = is_wait(state_q) && (sup_i == want_live(state_q));
    assign accept  = (state_q == ST_IDLE) && start_i && healthy_i && !alarm_o;

    assign timer_clear_o = !is_wait(state_q) || matched || !healthy_i;
    assign busy_o        = is_wait(state_q);
    assign drop_o[0]     = (state_q == ST_DROP1);
    assign drop_o[1]     = (state_q == ST_DROP2);

    // Phase that follows a successful check
    always_comb begin
        case (state_q)
            ST_DROP1:  state_nxt = ST_RAISE1;
            ST_RAISE1: state_nxt = ST_DROP2;
            ST_DROP2:  state_nxt = ST_RAISE2;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    // Phase register, alarm latch and pass pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            alarm_o <= 1'b0;
            pass_o  <= 1'b0;
        end else begin
            pass_o <= 1'b0;
            if (state_q == ST_IDLE) begin
                if (accept) state_q <= ST_DROP1;
            end else if (!healthy_i) begin
                state_q <= ST_IDLE;
            end else if (matched) begin
                state_q <= state_nxt;
                if (state_q == ST_RAISE2) pass_o <= 1'b1;
            end else if (expired_i) begin
                alarm_o <= 1'b1;
                state_q <= ST_IDLE;
            end
        end
    end

    // R8: the alarm stays latched until reset
    assert_alarm_latched_R8: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_o |=> alarm_o);

    // R8: an alarmed idle block never starts a test
    assert_no_start_alarmed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_o && state_q == ST_IDLE) |=> !busy_o);

    // R6: the pass pulse lasts one cycle and follows the last check
    assert_pass_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pass_o |=> !pass_o);
    assert_pass_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pass_o) |-> ($past(state_q) == ST_RAISE2) && !busy_o);

    // R7: an alarm only rises after the timer has expired
    assert_alarm_needs_expiry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_o) |-> $past(expired_i) && $past(busy_o));

    // R3: at most one relay is dropped by the sequence at a time
    assert_single_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(drop_o));

    // R9: losing health during a test returns to idle
    assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !healthy_i) |=> !busy_o && !pass_o);
endmodule

// File: rtl/hrst_relay_drive.sv
// Health-relay drive stage.
// Each relay is energised only while the evaluator is healthy, no alarm is
// latched, and the sequencer is not dropping that relay. This stage has no
// state of its own.
module hrst_relay_drive #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         healthy_i,
    input  logic         alarm_i,
    input  logic [N-1:0] drop_i,
    output logic [N-1:0] relay_o
);
    // One gated drive per health relay
    for (genvar k = 0; k < N; k++) begin : g_relay
        assign relay_o[k] = healthy_i && !alarm_i && !drop_i[k];

        // R8: an alarm forces this relay off
        assert_alarm_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
            alarm_i |-> !relay_o[k]);
    end
endmodule

// File: rtl/hrst_top.sv
// Top of the staged dual health-relay self-test.
// It ties together the phase sequencer, the wait timer and the relay drive
// stage. Assumes sup_i and healthy_i are synchronous to clk.
module hrst_top #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          healthy_i,
    input  logic          start_i,
    input  logic          sup_i,
    input  logic [TW-1:0] timeout_i,
    output logic          relay1_o,
    output logic          relay2_o,
    output logic          busy_o,
    output logic          pass_o,
    output logic          alarm_o
);
    import hrst_pkg::*;

    logic                  timer_clear;
    logic                  expired;
    logic [NUM_HEALTH-1:0] drop;
    logic [NUM_HEALTH-1:0] relay;

    hrst_sequencer u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .healthy_i    (healthy_i),
        .start_i      (start_i),
        .sup_i        (sup_i),
        .expired_i    (expired),
        .timer_clear_o(timer_clear),
        .drop_o       (drop),
        .busy_o       (busy_o),
        .pass_o       (pass_o),
        .alarm_o      (alarm_o)
    );

    hrst_wait_timer #(.TW(TW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (timer_clear),
        .limit_i  (timeout_i),
        .expired_o(expired)
    );

    hrst_relay_drive #(.N(NUM_HEALTH)) u_drv (
        .clk      (clk),
        .rst_n    (rst_n),
        .healthy_i(healthy_i),
        .alarm_i  (alarm_o),
        .drop_i   (drop),
        .relay_o  (relay)
    );

    assign relay1_o = relay[0];
    assign relay2_o = relay[1];

    // R1: in idle without alarm, the relays track health
    assert_idle_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !alarm_o) |-> (relay1_o == healthy_i) && (relay2_o == healthy_i));
endmodule

// File: tb/sim_hrst_top.sv
// Testbench for hrst_top: a behavioural reference model and a delayed-bus
// plant, compared on every clock.
module sim_hrst_top;
    localparam int CLK_PERIOD = 10;
    localparam int TW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          healthy = 1'b1;
    logic          start = 1'b0;
    logic          sup = 1'b1;
    logic [TW-1:0] tmo = '0;
    logic          relay1, relay2, busy, pass, alarm;

    int n_checks = 0;
    int n_fail   = 0;

    // Reference model state: 0 idle, 1 drop1, 2 raise1, 3 drop2, 4 raise2
    int ms = 0, mc = 0;
    bit ma = 0, mp = 0;

    // Plant: bus-live history, delay, stuck modes (0 none, 1 stuck on, 2 stuck off)
    bit hist[$];
    int dly = 0;
    int stuck = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hrst_top #(.TW(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .healthy_i(healthy), .start_i(start),
        .sup_i(sup), .timeout_i(tmo),
        .relay1_o(relay1), .relay2_o(relay2), .busy_o(busy),
        .pass_o(pass), .alarm_o(alarm)
    );

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    task automatic check_bit(input string tag, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic bit exp_r1(); return !ma && healthy && ms != 1; endfunction
    function automatic bit exp_r2(); return !ma && healthy && ms != 3; endfunction

    // One clock: drive sup from the plant, compare, advance the model
    task automatic tick();
        string rt;
        bit live, want;
        live = exp_r1() && exp_r2();
        hist.push_front(live);
        if (hist.size() > 64) void'(hist.pop_back());
        if (stuck == 1)      sup = 1'b1;
        else if (stuck == 2) sup = 1'b0;
        else                 sup = (hist.size() > dly) ? hist[dly] : 1'b1;
        #1;
        if (rst_n) begin
            rt = (ms == 1) ? "R3" : (ms == 2) ? "R4" : (ms >= 3) ? "R5" : ma ? "R8" : "R1";
            check_bit(rt, "relay1", relay1, exp_r1());
            check_bit(rt, "relay2", relay2, exp_r2());
            check_bit("R2", "busy", busy, ms != 0);
            check_bit("R6", "pass", pass, mp);
            check_bit("R7", "alarm", alarm, ma);
        end
        // next-state of the reference model
        mp = 0;
        if (!rst_n) begin
            ms = 0; mc = 0; ma = 0;
        end else if (ms == 0) begin
            mc = 0;
            if (start && healthy && !ma) ms = 1;
        end else if (!healthy) begin
            ms = 0; mc = 0;
        end else begin
            want = (ms == 2) || (ms == 4);
            if (sup == want) begin
                if (ms == 4) begin ms = 0; mp = 1; end
                else ms = ms + 1;
                mc = 0;
            end else if (mc >= int'(tmo)) begin
                ma = 1; ms = 0; mc = 0;
            end else begin
                mc = mc + 1;
            end
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    // Request a test and run until it ends; report the outcome
    task automatic run_test(input int d, input int to, input int sm,
                            output bit saw_pass, output bit saw_alarm);
        dly = d; stuck = sm; tmo = TW'(to);
        saw_pass = 0;
        start = 1'b1; tick(); start = 1'b0;
        for (int i = 0; i < 400 && busy; i++) begin
            tick();
            if (pass) saw_pass = 1;
        end
        if (pass) saw_pass = 1;
        saw_alarm = alarm;
        tick();
        stuck = 0;
    endtask

    initial begin
        bit p, a;
        @(negedge clk);
        rst_n = 1'b0; tick(); tick();
        rst_n = 1'b1;
        #1;
        // R10: reset state
        check_bit("R10", "busy after reset", busy, 1'b0);
        check_bit("R10", "alarm after reset", alarm, 1'b0);
        check_bit("R10", "pass after reset", pass, 1'b0);
        repeat (3) tick();

        // R1: idle relays follow health
        healthy = 1'b0; tick();
        check_bit("R1", "relay1 unhealthy idle", relay1, 1'b0);
        // R2: start while unhealthy is ignored
        start = 1'b1; tick(); tick(); start = 1'b0;
        check_bit("R2", "busy after unhealthy start", busy, 1'b0);
        healthy = 1'b1; repeat (2) tick();

        // R3 R4 R5 R6: normal runs with various bus delays
        run_test(2, 5, 0, p, a);
        check_bit("R6", "pass with delay 2", p, 1'b1);
        run_test(0, 0, 0, p, a);
        check_bit("R5", "pass with delay 0 timeout 0", p, 1'b1);
        // R7: response on the last allowed cycle passes; one later fails
        run_test(4, 4, 0, p, a);
        check_bit("R7", "pass at delay equal to timeout", p, 1'b1);
        check_bit("R7", "no alarm at delay equal to timeout", a, 1'b0);

        // R9: health loss mid-test aborts without alarm
        dly = 3; tmo = 10; start = 1'b1; tick(); start = 1'b0;
        repeat (2) tick();
        healthy = 1'b0; tick(); tick();
        check_bit("R9", "busy after abort", busy, 1'b0);
        check_bit("R9", "alarm after abort", alarm, 1'b0);
        healthy = 1'b1; repeat (6) tick();

        run_test(5, 4, 0, p, a);
        check_bit("R7", "alarm at delay one past timeout", a, 1'b1);
        check_bit("R8", "no pass on failure", p, 1'b0);
        // R8: alarmed block ignores start and keeps relays off
        start = 1'b1; tick(); tick(); start = 1'b0;
        check_bit("R8", "busy while alarmed", busy, 1'b0);
        check_bit("R8", "relay2 off while alarmed", relay2, 1'b0);

        // R10: reset clears the alarm; stuck-on bus fails in the first phase
        rst_n = 1'b0; tick(); rst_n = 1'b1; #1;
        check_bit("R10", "alarm cleared by reset", alarm, 1'b0);
        repeat (2) tick();
        run_test(0, 3, 1, p, a);
        check_bit("R3", "stuck-on supervision raises alarm", a, 1'b1);
        rst_n = 1'b0; tick(); rst_n = 1'b1; repeat (2) tick();
        // R4: bus that never returns fails in the second phase
        run_test(0, 3, 2, p, a);
        check_bit("R4", "stuck-off supervision raises alarm", a, 1'b1);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule